// File: doc/BRIEF.md
# Start-up Mode Sequencer

This block brings a fixed-function device out of power-on reset and into user operation. A mode strap, captured only while the power-on reset is asserted, chooses one of three start-up behaviours: release straight away, release after a fixed wait counted in clock cycles, or imitate a serial configuration load. In the last case the block counts configuration clock pulses until a programmed total is reached.

While the block is in its start-up phase it holds the user logic in reset and pulls the open-drain "configuration finished" pin low. When start-up ends, it stops driving that pin, so the pin goes to high impedance, and it releases the user reset in the same cycle. In emulation mode, the active-low configuration restart input clears the pulse count at any time. If the block is already in user operation, the same input returns it to the emulating phase. A status output reports the current phase and a parity bit taken over the configuration data that has been accepted.

Top module: `startup_seq`

## Requirements
- R1: The mode strap `mode_i` is captured on each clock edge while `rst_ni` is low. The codes are 2'b00 immediate, 2'b01 delayed, 2'b10 emulation, and 2'b11 behaves as immediate.
- R2: While `rst_ni` is low, `user_rst_no` = 0, `conf_done_oe_o` = 1, `conf_done_o` = 0 and `status_o[1:0]` = 2'b00.
- R3: In immediate mode, user reset is released at the first rising clock edge after `rst_ni` goes high.
- R4: In delayed mode, user reset is released exactly DELAY_CYC clock edges later than in immediate mode. `status_o[1:0]` reads 2'b01 during the wait.
- R5: `conf_done_oe_o` is high with `conf_done_o` low exactly when user reset is asserted. The output enable drops in the same cycle that `user_rst_no` rises.
- R6: In emulation mode, user reset is released after BIT_COUNT synchronized rising edges of `cfg_clk_i` have been seen while `cfg_restart_ni` is high. It stays asserted after BIT_COUNT-1 such edges.
- R7: In emulation mode, `cfg_restart_ni` low clears the pulse count and the parity. If the block is in user operation, this returns it to the emulating phase (`status_o[1:0]` = 2'b10), with the pin driven low and user reset asserted.
- R8: In immediate and delayed modes, the configuration inputs have no effect on any output.
- R9: Changes on `mode_i` after `rst_ni` has gone high have no effect.
- R10: `status_o[1:0]` encodes the phase: 00 hold, 01 waiting, 10 emulating, 11 user. `status_o[2]` is the XOR of every `cfg_data_i` bit accepted on a counted clock edge since the last clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| mode_i | input | 2 | Start-up mode strap |
| cfg_restart_ni | input | 1 | Configuration restart, active low |
| cfg_clk_i | input | 1 | Configuration clock, asynchronous to clk_i |
| cfg_data_i | input | 1 | Configuration serial data |
| user_rst_no | output | 1 | User logic reset, active low |
| conf_done_o | output | 1 | Value driven on the done pin |
| conf_done_oe_o | output | 1 | Output enable of the done pin |
| status_o | output | 3 | Parity bit and phase code |

## Verification
The bench builds the block with DELAY_CYC = 40 and BIT_COUNT = 24, which stand in for the production wait and stream length. With these values, the exact release edge of the delayed mode can be reached within a few dozen cycles. The emulation threshold can be approached from both sides, one pulse short and exactly on count. A restart can also be placed mid-stream, where a count that failed to clear would release early, and the parity result can be checked against a short stream computed in the bench.

// File: rtl/startup_pkg.sv
package startup_pkg;
  typedef enum logic [1:0] {
    MODE_IMM   = 2'b00,
    MODE_DELAY = 2'b01,
    MODE_EMUL  = 2'b10,
    MODE_IMM2  = 2'b11
  } mode_e;

  typedef enum logic [1:0] {
    PH_HOLD = 2'b00,
    PH_WAIT = 2'b01,
    PH_EMUL = 2'b10,
    PH_USER = 2'b11
  } phase_e;
endpackage

// File: rtl/startup_sync.sv
module startup_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/startup_timer.sv
module startup_timer #(
  parameter int DELAY_CYC = 5_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(DELAY_CYC + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == CW'(DELAY_CYC - 1));
endmodule

// File: rtl/startup_bitcount.sv
module startup_bitcount #(
  parameter int BIT_COUNT = 1_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic step_i,
  input  logic bit_i,
  output logic last_o,
  output logic parity_o
);
  localparam int CW = $clog2(BIT_COUNT + 1);
  logic [CW-1:0] cnt_q;
  logic          par_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      par_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q <= '0;
      par_q <= 1'b0;
    end else if (step_i) begin
      cnt_q <= last_o ? cnt_q : cnt_q + 1'b1;
      par_q <= par_q ^ bit_i;
    end
  end

  assign last_o   = step_i && (cnt_q == CW'(BIT_COUNT - 1));
  assign parity_o = par_q;
endmodule

// File: rtl/startup_seq.sv
module startup_seq
  import startup_pkg::*;
#(
  parameter int DELAY_CYC   = 5_000_000,
  parameter int BIT_COUNT   = 1_000_000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       cfg_restart_ni,
  input  logic       cfg_clk_i,
  input  logic       cfg_data_i,
  output logic       user_rst_no,
  output logic       conf_done_o,
  output logic       conf_done_oe_o,
  output logic [2:0] status_o
);
  mode_e  mode_q;
  phase_e phase_q, phase_d;
  logic   ncfg_s, data_s, dclk_s, dclk_d;
  logic   dclk_rise, emul_sel, wait_done, bc_last, bc_parity, bc_clear, bc_step;

  // strap capture follows reset level, no reset of its own
  always_ff @(posedge clk_i) begin
    if (!rst_ni) mode_q <= mode_e'(mode_i);
  end

  startup_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cfg_restart_ni, cfg_data_i, cfg_clk_i}),
    .q_o   ({ncfg_s, data_s, dclk_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dclk_d <= 1'b0;
    else         dclk_d <= dclk_s;
  end

  assign dclk_rise = dclk_s && !dclk_d;
  assign emul_sel  = (mode_q == MODE_EMUL);
  assign bc_clear  = (phase_q == PH_HOLD) || (emul_sel && !ncfg_s);
  assign bc_step   = (phase_q == PH_EMUL) && ncfg_s && dclk_rise;

  startup_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (phase_q == PH_WAIT),
    .done_o(wait_done)
  );

  startup_bitcount #(.BIT_COUNT(BIT_COUNT)) u_bits (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (bc_clear),
    .step_i  (bc_step),
    .bit_i   (data_s),
    .last_o  (bc_last),
    .parity_o(bc_parity)
  );

  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_HOLD: begin
        if (mode_q == MODE_DELAY)     phase_d = PH_WAIT;
        else if (mode_q == MODE_EMUL) phase_d = PH_EMUL;
        else                          phase_d = PH_USER;
      end
      PH_WAIT: if (wait_done) phase_d = PH_USER;
      PH_EMUL: if (bc_last)   phase_d = PH_USER;
      PH_USER: if (emul_sel && !ncfg_s) phase_d = PH_EMUL;
      default: phase_d = PH_HOLD;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_HOLD;
    else         phase_q <= phase_d;
  end

  assign user_rst_no    = (phase_q == PH_USER);
  assign conf_done_oe_o = (phase_q != PH_USER);
  assign conf_done_o    = 1'b0;
  assign status_o       = {bc_parity, phase_q};
endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] phase_i,
  input logic [1:0] mode_i,
  input logic       ncfg_i,
  input logic       user_rst_ni,
  input logic       oe_i,
  input logic       done_i
);
  AST_RELEASE_SAME_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (user_rst_ni != oe_i)) else $error("oe and user reset disagree"); // R5

  AST_DRIVE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |-> !done_i) else $error("done pin driven high"); // R5

  AST_IMM_NEXT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 2'b00 && mode_i[1] == mode_i[0]) |=> user_rst_ni)
    else $error("immediate release late"); // R3

  AST_DELAY_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_i == 2'b00 && mode_i == 2'b01) |=> (phase_i == 2'b01))
    else $error("delay wait not entered"); // R4

  AST_RESTART_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && !ncfg_i) |=> (oe_i && phase_i == 2'b10))
    else $error("restart did not hold"); // R7

  AST_USER_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (user_rst_ni && mode_i != 2'b10) |=> user_rst_ni)
    else $error("user reset reasserted"); // R8

  AST_MODE_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(mode_i)) else $error("mode changed"); // R9
endmodule

bind startup_seq startup_seq_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .phase_i    (phase_q),
  .mode_i     (mode_q),
  .ncfg_i     (ncfg_s),
  .user_rst_ni(user_rst_no),
  .oe_i       (conf_done_oe_o),
  .done_i     (conf_done_o)
);

// File: tb/startup_seq_test.sv
module startup_seq_test;
  localparam int DLY  = 40;
  localparam int BITS = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       ncfg = 1'b1, dclk = 1'b0, data = 1'b0;
  logic       user_rst_n, done, done_oe;
  logic [2:0] status;
  int         n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  startup_seq #(.DELAY_CYC(DLY), .BIT_COUNT(BITS), .SYNC_STAGES(2)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .cfg_restart_ni(ncfg),
    .cfg_clk_i(dclk), .cfg_data_i(data), .user_rst_no(user_rst_n),
    .conf_done_o(done), .conf_done_oe_o(done_oe), .status_o(status)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode = m; ncfg = 1'b1; dclk = 1'b0; data = 1'b0;
    cycles(3);
    rst_n = 1'b1;
  endtask

  task automatic pulse(input logic b);
    dclk = 1'b1; data = b;
    cycles(3);
    dclk = 1'b0;
    cycles(3);
  endtask

  function automatic logic pbit(input int i);
    return ((i * 7) % 5) < 2;
  endfunction

  task automatic t_reset_state();
    @(negedge clk); rst_n = 1'b0; mode = 2'b10;
    cycles(2);
    check("R2 user_rst", user_rst_n, 0);
    check("R2 oe", done_oe, 1);
    check("R2 done", done, 0);
    check("R2 phase", status[1:0], 2'b00);
  endtask

  task automatic t_immediate(input logic [1:0] m);
    do_reset(m);
    check("R5 held at release", done_oe, 1);
    cycles(1);
    check("R3 released", user_rst_n, 1);
    check("R5 oe dropped", done_oe, 0);
    check("R1 phase user", status[1:0], 2'b11);
  endtask

  task automatic t_delay();
    do_reset(2'b01);
    cycles(DLY);
    check("R4 still held", user_rst_n, 0);
    check("R4 phase wait", status[1:0], 2'b01);
    check("R5 driven low", {done_oe, done}, 2'b10);
    cycles(1);
    check("R4 released", user_rst_n, 1);
    check("R5 oe dropped", done_oe, 0);
    ncfg = 1'b0; pulse(1'b1); pulse(1'b0);
    cycles(4);
    check("R8 cfg ignored", {user_rst_n, done_oe, status}, {2'b10, 3'b011});
    ncfg = 1'b1;
  endtask

  task automatic t_mode_frozen();
    do_reset(2'b01);
    mode = 2'b00;
    cycles(5);
    check("R9 mode ignored", user_rst_n, 0);
    check("R9 phase wait", status[1:0], 2'b01);
    cycles(DLY);
    check("R9 release", user_rst_n, 1);
  endtask

  task automatic t_emul();
    logic par = 1'b0;
    do_reset(2'b10);
    cycles(3);
    check("R10 phase emul", status[1:0], 2'b10);
    for (int i = 0; i < 10; i++) pulse(1'b1);
    ncfg = 1'b0; cycles(5);
    check("R7 held on restart", done_oe, 1);
    ncfg = 1'b1; cycles(4);
    for (int i = 0; i < BITS - 1; i++) begin
      pulse(pbit(i)); par ^= pbit(i);
    end
    check("R6 one short", user_rst_n, 0);
    check("R7 count restarted", done_oe, 1);
    pulse(pbit(BITS - 1)); par ^= pbit(BITS - 1);
    check("R6 released", user_rst_n, 1);
    check("R5 oe dropped", done_oe, 0);
    check("R10 parity", status, {par, 2'b11});
    ncfg = 1'b0; cycles(5);
    check("R7 back to emul", status[1:0], 2'b10);
    check("R7 rst asserted", user_rst_n, 0);
    check("R7 driven low", {done_oe, done}, 2'b10);
    check("R7 parity cleared", status[2], 0);
    ncfg = 1'b1; cycles(4);
    par = 1'b0;
    for (int i = 0; i < BITS; i++) begin
      pulse(pbit(i + 3)); par ^= pbit(i + 3);
    end
    check("R6 re-released", user_rst_n, 1);
    check("R10 parity again", status[2], par);
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset_state();
    t_immediate(2'b00);
    t_immediate(2'b11);
    t_delay();
    t_mode_frozen();
    t_emul();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule